// File: doc/BRIEF.md
# Preload Initial-Value Copier

This block rebuilds the starting contents of a working RAM before each run of a time-stepped compute engine. A register reset does not touch RAM storage, so the values a previous run left behind would otherwise seed the next run. On a start pulse, a small sequencer walks a read address through a table of initial values. Some entries of that table are zeros for transient state quantities. The others are case-specific constants, such as source amplitudes and phase offsets. The sequencer writes each word into the RAM at the address it was read from.

The table has a two-cycle read latency. The write address and the write enable therefore pass through a two-stage delay line that runs beside the table pipeline, so each word lands where it came from. A preload flag drives four multiplexers on the RAM's write enable, write address, write data and read address. While the flag is high, the copy path owns the RAM. While it is low, the compute side owns the RAM. A done level tells the compute side that the copy has finished.

Top module: `init_loader`

## Requirements
- R1: After reset, pre_flag_o and done_o are low. A reset does not change any word held in the RAM.
- R2: When start_i is high at a clock edge while no copy is running, a copy begins and pre_flag_o is high from the next cycle.
- R3: The table word at address a is 0 for a < ZERO_WORDS. Otherwise it is (AMP_BASE + a*PHASE_STEP) mod 2^DW.
- R4: After a completed copy, every RAM address from 0 to DEPTH-1 holds the table word of that same address.
- R5: pre_flag_o stays high for exactly DEPTH+2 cycles. done_o rises DEPTH+3 clock edges after the edge that sampled start_i, counting that edge, and stays high until the next accepted start.
- R6: While pre_flag_o is high, the compute-side write inputs have no effect on the RAM.
- R7: A start_i pulse during a running copy is ignored. The copy's timing and result are unchanged.
- R8: While pre_flag_o is low, a write on cmp_we_i stores cmp_wdata_i at cmp_waddr_i. rdata_o shows the word at cmp_raddr_i one cycle after the address is applied.
- R9: A reset in the middle of a copy aborts it and clears pre_flag_o and done_o. A later start performs a full copy.
- R10: During a copy, the read addresses are issued once each, in order, from 0 to DEPTH-1, on consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset for registers only |
| start_i | input | 1 | Starts a copy when no copy is running |
| cmp_we_i | input | 1 | Compute-side write enable |
| cmp_waddr_i | input | AW | Compute-side write address |
| cmp_wdata_i | input | DW | Compute-side write data |
| cmp_raddr_i | input | AW | Compute-side read address |
| rdata_o | output | DW | RAM read data, one cycle after the read address |
| pre_flag_o | output | 1 | High while the copy path owns the RAM |
| done_o | output | 1 | High once the last initial word has been written |

## Verification
The bench fills the RAM with junk, resets, and reads the junk back. A design that reset the RAM, or that relied on reset to initialise it, fails here. It counts the exact edge on which done_o rises. A copier whose write pipeline was not delayed, or whose flag dropped before the final write, would leave the last address or every address shifted by the latency. The bench hammers the compute write port and re-pulses start during a copy. It also aborts a copy with reset and then restarts it. A mux with an inverted select, or a sequencer that restarts mid-run, shows up as wrong contents or a shifted done edge.

// File: rtl/init_loader_pkg.sv
package init_loader_pkg;
  localparam int unsigned ROM_LAT = 2;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_RUN   = 2'd1,
    ST_DRAIN = 2'd2,
    ST_DONE  = 2'd3
  } seq_state_e;
endpackage

// File: rtl/delay_pipe.sv
module delay_pipe #(
  parameter int unsigned W      = 8,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stg_q [STAGES+1];
  assign stg_q[0] = d_i;

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) stg_q[s+1] <= '0;
      else         stg_q[s+1] <= stg_q[s];
    end
  end

  assign q_o = stg_q[STAGES];
endmodule

// File: rtl/init_rom.sv
module init_rom #(
  parameter int unsigned DEPTH      = 16,
  parameter int unsigned DW         = 16,
  parameter int unsigned ZERO_WORDS = 6,
  parameter int unsigned AMP_BASE   = 32'h1200,
  parameter int unsigned PHASE_STEP = 32'h0135,
  localparam int unsigned AW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [AW-1:0] raddr_i,
  output logic [DW-1:0] rdata_o
);
  logic [AW-1:0] addr_q;
  logic [DW-1:0] data_q;

  // Table content is computed, not stored.
  function automatic logic [DW-1:0] word_at(input logic [AW-1:0] a);
    if (int'(a) < int'(ZERO_WORDS)) return '0;
    return DW'(AMP_BASE) + DW'(a) * DW'(PHASE_STEP);
  endfunction

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_q <= '0;
      data_q <= '0;
    end else begin
      addr_q <= raddr_i;
      data_q <= word_at(addr_q);
    end
  end

  assign rdata_o = data_q;
endmodule

// File: rtl/copy_seq.sv
module copy_seq
  import init_loader_pkg::*;
#(
  parameter int unsigned DEPTH = 16,
  localparam int unsigned AW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  output logic          rd_en_o,
  output logic [AW-1:0] rd_addr_o,
  output logic          pre_flag_o,
  output logic          done_o
);
  localparam logic [AW-1:0] LAST_ADDR = AW'(DEPTH - 1);
  localparam int unsigned   DRW = (ROM_LAT > 1) ? $clog2(ROM_LAT) : 1;

  seq_state_e     state_q, state_d;
  logic [AW-1:0]  cnt_q, cnt_d;
  logic [DRW-1:0] drn_q, drn_d;

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    drn_d   = drn_q;
    unique case (state_q)
      ST_IDLE, ST_DONE: begin
        if (start_i) begin
          state_d = ST_RUN;
          cnt_d   = '0;
        end
      end
      ST_RUN: begin
        if (cnt_q == LAST_ADDR) begin
          state_d = ST_DRAIN;
          drn_d   = '0;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      ST_DRAIN: begin
        // hold flag until the last delayed write lands
        if (drn_q == DRW'(ROM_LAT - 1)) state_d = ST_DONE;
        else                            drn_d   = drn_q + 1'b1;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      drn_q   <= '0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      drn_q   <= drn_d;
    end
  end

  assign rd_en_o    = (state_q == ST_RUN);
  assign rd_addr_o  = cnt_q;
  assign pre_flag_o = (state_q == ST_RUN) || (state_q == ST_DRAIN);
  assign done_o     = (state_q == ST_DONE);

  // R10
  addr_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_en_o && $past(rd_en_o)) |-> (rd_addr_o == $past(rd_addr_o) + 1'b1));

  // R10
  addr_first_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rd_en_o) |-> (rd_addr_o == '0));

  // R5
  flag_done_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(pre_flag_o && done_o));
endmodule

// File: rtl/ram_port_mux.sv
module ram_port_mux #(
  parameter int unsigned AW = 4,
  parameter int unsigned DW = 16
) (
  input  logic          sel_copy_i,
  input  logic          cp_we_i,
  input  logic [AW-1:0] cp_waddr_i,
  input  logic [DW-1:0] cp_wdata_i,
  input  logic [AW-1:0] cp_raddr_i,
  input  logic          cm_we_i,
  input  logic [AW-1:0] cm_waddr_i,
  input  logic [DW-1:0] cm_wdata_i,
  input  logic [AW-1:0] cm_raddr_i,
  output logic          we_o,
  output logic [AW-1:0] waddr_o,
  output logic [DW-1:0] wdata_o,
  output logic [AW-1:0] raddr_o
);
  assign we_o    = sel_copy_i ? cp_we_i    : cm_we_i;
  assign waddr_o = sel_copy_i ? cp_waddr_i : cm_waddr_i;
  assign wdata_o = sel_copy_i ? cp_wdata_i : cm_wdata_i;
  assign raddr_o = sel_copy_i ? cp_raddr_i : cm_raddr_i;
endmodule

// File: rtl/work_ram.sv
module work_ram #(
  parameter int unsigned DEPTH = 16,
  parameter int unsigned DW    = 16,
  localparam int unsigned AW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic          clk_i,
  input  logic          we_i,
  input  logic [AW-1:0] waddr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic [AW-1:0] raddr_i,
  output logic [DW-1:0] rdata_o
);
  // Storage has no reset on purpose.
  logic [DW-1:0] mem_q [DEPTH];

  always_ff @(posedge clk_i) begin
    if (we_i) mem_q[waddr_i] <= wdata_i;
    rdata_o <= mem_q[raddr_i];
  end
endmodule

// File: rtl/init_loader.sv
module init_loader
  import init_loader_pkg::*;
#(
  parameter int unsigned DEPTH      = 16,
  parameter int unsigned DW         = 16,
  parameter int unsigned ZERO_WORDS = 6,
  parameter int unsigned AMP_BASE   = 32'h1200,
  parameter int unsigned PHASE_STEP = 32'h0135,
  localparam int unsigned AW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic          cmp_we_i,
  input  logic [AW-1:0] cmp_waddr_i,
  input  logic [DW-1:0] cmp_wdata_i,
  input  logic [AW-1:0] cmp_raddr_i,
  output logic [DW-1:0] rdata_o,
  output logic          pre_flag_o,
  output logic          done_o
);
  logic          rom_en;
  logic [AW-1:0] rom_raddr;
  logic [DW-1:0] rom_rdata;
  logic          cp_we;
  logic [AW-1:0] cp_waddr;
  logic          ram_we;
  logic [AW-1:0] ram_waddr, ram_raddr;
  logic [DW-1:0] ram_wdata;

  copy_seq #(.DEPTH(DEPTH)) u_seq (
    .clk_i, .rst_ni, .start_i,
    .rd_en_o   (rom_en),
    .rd_addr_o (rom_raddr),
    .pre_flag_o,
    .done_o
  );

  init_rom #(
    .DEPTH(DEPTH), .DW(DW), .ZERO_WORDS(ZERO_WORDS),
    .AMP_BASE(AMP_BASE), .PHASE_STEP(PHASE_STEP)
  ) u_rom (
    .clk_i, .rst_ni,
    .raddr_i (rom_raddr),
    .rdata_o (rom_rdata)
  );

  // Write side trails the table by its read latency.
  delay_pipe #(.W(AW + 1), .STAGES(ROM_LAT)) u_wr_dly (
    .clk_i, .rst_ni,
    .d_i ({rom_en, rom_raddr}),
    .q_o ({cp_we, cp_waddr})
  );

  ram_port_mux #(.AW(AW), .DW(DW)) u_mux (
    .sel_copy_i (pre_flag_o),
    .cp_we_i    (cp_we),
    .cp_waddr_i (cp_waddr),
    .cp_wdata_i (rom_rdata),
    .cp_raddr_i ('0),
    .cm_we_i    (cmp_we_i),
    .cm_waddr_i (cmp_waddr_i),
    .cm_wdata_i (cmp_wdata_i),
    .cm_raddr_i (cmp_raddr_i),
    .we_o       (ram_we),
    .waddr_o    (ram_waddr),
    .wdata_o    (ram_wdata),
    .raddr_o    (ram_raddr)
  );

  work_ram #(.DEPTH(DEPTH), .DW(DW)) u_ram (
    .clk_i,
    .we_i    (ram_we),
    .waddr_i (ram_waddr),
    .wdata_i (ram_wdata),
    .raddr_i (ram_raddr),
    .rdata_o
  );

  // R4
  wr_align_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cp_we |-> ($past(rom_en, 2) && cp_waddr == $past(rom_raddr, 2)));

  // R6
  copy_in_flag_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cp_we |-> pre_flag_o);

  // R5
  done_lat_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(done_o) |-> ($past(rom_en, 3) && !$past(rom_en, 2)
                       && $past(rom_raddr, 3) == AW'(DEPTH - 1)));
endmodule

// File: tb/tb_init_loader.sv
module tb_init_loader;
  localparam int DEPTH = 16;
  localparam int DW    = 16;
  localparam int AW    = 4;
  localparam int ZW    = 6;
  localparam int BASE  = 32'h1200;
  localparam int STEP  = 32'h0135;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
  logic cwe = 1'b0;
  logic [AW-1:0] cwa = '0, cra = '0;
  logic [DW-1:0] cwd = '0;
  logic [DW-1:0] rdata;
  logic pflag, done;
  int checks = 0, fails = 0;

  always #2.5 clk = ~clk;

  init_loader #(.DEPTH(DEPTH), .DW(DW), .ZERO_WORDS(ZW),
                .AMP_BASE(BASE), .PHASE_STEP(STEP)) dut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start),
    .cmp_we_i(cwe), .cmp_waddr_i(cwa), .cmp_wdata_i(cwd), .cmp_raddr_i(cra),
    .rdata_o(rdata), .pre_flag_o(pflag), .done_o(done));

  function automatic logic [DW-1:0] exp_init(int a);
    if (a < ZW) return '0;
    return DW'(BASE + a * STEP);
  endfunction

  function automatic logic [DW-1:0] junk(int a, int salt);
    return DW'(16'hA5C3 ^ (a * 16'h0911) ^ salt);
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic rd(int a, output logic [DW-1:0] v);
    @(negedge clk); cra = AW'(a);
    @(posedge clk); @(negedge clk); v = rdata;
  endtask

  task automatic wr(int a, logic [DW-1:0] d);
    @(negedge clk); cwe = 1'b1; cwa = AW'(a); cwd = d;
    @(negedge clk); cwe = 1'b0;
  endtask

  task automatic fill_junk(int salt);
    for (int a = 0; a < DEPTH; a++) wr(a, junk(a, salt));
  endtask

  task automatic verify_init(string req);
    logic [DW-1:0] v;
    for (int a = 0; a < DEPTH; a++) begin
      rd(a, v);
      chk(req, v, exp_init(a));
    end
  endtask

  // Pulses start, hammers compute writes, counts edges to done.
  task automatic run_copy(int restart_at, output int edges, output bit flag_ok);
    @(negedge clk); start = 1'b1;
    @(posedge clk); @(negedge clk); start = 1'b0;
    edges = 0; flag_ok = 1'b1;
    for (int n = 1; n < 100; n++) begin
      cwe = 1'b1; cwa = AW'(n); cwd = junk(n, 16'h7777);
      start = (n == restart_at);
      if (!pflag) flag_ok = 1'b0;
      @(posedge clk); @(negedge clk);
      edges = n;
      if (done) break;
    end
    cwe = 1'b0; start = 1'b0;
  endtask

  task automatic report();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    #(200000 * 5);
    checks++; fails++;
    $display("FAIL watchdog act=timeout exp=finish");
    report();
  end

  initial begin
    int edges;
    bit fok;
    logic [DW-1:0] v;

    repeat (3) @(negedge clk);
    chk("R1 flag in reset", pflag, 0);
    chk("R1 done in reset", done, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 flag after reset", pflag, 0);
    chk("R1 done after reset", done, 0);

    // compute path owns RAM while flag low
    fill_junk(1);
    rd(3, v); chk("R8 compute write/read", v, junk(3, 1));
    wr(9, 16'hBEEF);
    rd(9, v); chk("R8 compute overwrite", v, 16'hBEEF);
    wr(9, junk(9, 1));

    // reset leaves RAM untouched
    @(negedge clk); rst_n = 1'b0;
    repeat (2) @(negedge clk); rst_n = 1'b1;
    for (int a = 0; a < DEPTH; a++) begin
      rd(a, v); chk("R1 RAM kept over reset", v, junk(a, 1));
    end

    // full copy, with a mid-run start pulse and compute writes
    run_copy(5, edges, fok);
    chk("R5 done edge count", edges, DEPTH + 2);
    chk("R2 R5 flag held until done", fok, 1);
    chk("R5 flag low at done", pflag, 0);
    chk("R7 done reached despite restart", done, 1);
    verify_init("R3 R4 R6 R10 contents after copy");
    chk("R5 done held", done, 1);

    // flag low again: compute writes land
    wr(2, 16'h1234);
    rd(2, v); chk("R8 write after copy", v, 16'h1234);

    // restart from done with RAM dirty
    fill_junk(2);
    run_copy(0, edges, fok);
    chk("R2 restart from done", edges, DEPTH + 2);
    verify_init("R4 second copy");

    // abort mid copy with reset, then full copy
    fill_junk(3);
    @(negedge clk); start = 1'b1;
    @(posedge clk); @(negedge clk); start = 1'b0;
    chk("R2 flag after start", pflag, 1);
    chk("R2 done dropped on start", done, 0);
    repeat (6) @(negedge clk);
    rst_n = 1'b0;
    #1;
    chk("R9 flag cleared by reset", pflag, 0);
    chk("R9 done cleared by reset", done, 0);
    @(negedge clk); rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R9 stays idle after abort", {pflag, done}, 2'b00);
    run_copy(0, edges, fok);
    chk("R9 full copy after abort", edges, DEPTH + 2);
    verify_init("R9 contents after abort and restart");

    report();
  end
endmodule